// File: doc/BRIEF.md
# Instruction Field Decoder for an 8-bit Accumulator Datapath

This block takes a 16-bit instruction word and turns it into the control signals for a small 8-bit register datapath in the same time step, with no clock. The word carries a 3-bit source code, a 3-bit destination code, a memory write bit, a program-counter advance bit and an 8-bit immediate byte. The decoder sends the source code unchanged to every register input multiplexer as a shared select. It raises one load enable for the destination register and passes the write bit, the advance bit and the immediate byte on to the datapath.

Two debug controls sit in front of and behind the decode. A scan-select input makes the decoder use a word supplied by a debug scan chain in place of the fetched word. A suppress input holds every side effect low: no register loads, no memory write and no counter advance. The select and immediate outputs stay valid under suppress, so a debugger can still see them. Every port is a plain level, so there is no valid/ready handshake and no back-pressure. A word that is all zeros copies R0 into itself and changes nothing.

Top module: `micro_decoder`

## Requirements
- R1: `data_sel` equals bits 15:13 of the active word. The source codes are 0..3 for R0..R3, 4 for the destination's own value, 5 for the immediate, 6 for the adder/memory path and 7 for the scan value.
- R2: When bits 12:10 of the active word hold a code n from 0 to 3 and suppress is low, `gp_load` is one-hot with only bit n set, and `pc_load` is 0.
- R3: Destination code 4 with suppress low sets `pc_load` to 1 and `gp_load` to 0.
- R4: Destination codes 5, 6 and 7 set no load enable: `gp_load` is 0 and `pc_load` is 0.
- R5: `mem_wr` equals bit 9 of the active word while suppress is low.
- R6: `pc_step` equals bit 8 of the active word while suppress is low.
- R7: `imm_data` equals bits 7:0 of the active word.
- R8: When `scan_sel` is 1, the active word is `scan_word` and `fetch_word` has no effect on any output. When `scan_sel` is 0, the active word is `fetch_word`.
- R9: When `suppress` is 1, `gp_load`, `pc_load`, `mem_wr` and `pc_step` are all 0, while `data_sel` and `imm_data` still follow R1 and R7.
- R10: The word 16'h0000 gives `data_sel`=0 and `gp_load`=4'b0001, with `pc_load`, `mem_wr` and `pc_step` all 0, so R0 reloads its own value.
- R11: At most one of the five load enables is high at any time, and every output follows its inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_word | input | 16 | Instruction word from the instruction register |
| scan_word | input | 16 | Substitute word from the debug scan chain |
| scan_sel | input | 1 | 1 = decode scan_word instead of fetch_word |
| suppress | input | 1 | 1 = force all side-effect outputs low |
| data_sel | output | 3 | Shared data-in select for all register muxes |
| gp_load | output | 4 | Load enables for R0..R3, bit n for Rn |
| pc_load | output | 1 | Program counter load enable |
| mem_wr | output | 1 | Memory write enable |
| pc_step | output | 1 | Program counter count enable |
| imm_data | output | 8 | Immediate byte |

## Verification
Directed words walk the destination code through all eight values, so the one-hot register loads, the counter load and the three unused codes are each told apart. The all-zero word is applied on its own to confirm the no-op. Pairs of different fetch and scan words are applied with scan select on and off. While scan select is high the fetch word is changed alone, and the outputs must not move, which shows which word is decoded. Thousands of random words with random control bits then cover the mix of write, advance and suppress, and show that suppress clears only the side effects and leaves the select and immediate intact.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W  = 16;
  localparam int SEL_W   = 3;
  localparam int DST_W   = 3;
  localparam int IMM_W   = 8;
  localparam int IMM_LSB = 0;
  localparam int STEP_BIT = IMM_LSB + IMM_W;
  localparam int WR_BIT   = STEP_BIT + 1;
  localparam int DST_LSB  = WR_BIT + 1;
  localparam int SRC_LSB  = DST_LSB + DST_W;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic             wr;
    logic             step;
    logic [IMM_W-1:0] imm;
  } instr_fields_t;
endpackage

// File: rtl/idec_word_pick.sv
module idec_word_pick #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] primary,
  input  logic [WIDTH-1:0] alternate,
  input  logic             pick_alt,
  output logic [WIDTH-1:0] chosen
);
  always_comb chosen = pick_alt ? alternate : primary;
endmodule

// File: rtl/idec_field_split.sv
module idec_field_split
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output instr_fields_t     fields
);
  always_comb begin
    fields.src  = word[SRC_LSB +: SEL_W];
    fields.dst  = word[DST_LSB +: DST_W];
    fields.wr   = word[WR_BIT];
    fields.step = word[STEP_BIT];
    fields.imm  = word[IMM_LSB +: IMM_W];
  end
endmodule

// File: rtl/idec_dest_decode.sv
module idec_dest_decode #(
  parameter int CODE_W = 3,
  parameter int NUM_GP = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [NUM_GP-1:0] gp_hit,
  output logic              pc_hit
);
  localparam logic [CODE_W-1:0] PC_CODE = CODE_W'(NUM_GP);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_reg
    localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g);
    assign gp_hit[g] = (code == MY_CODE);
  end

  assign pc_hit = (code == PC_CODE);
endmodule

// File: rtl/idec_side_gate.sv
module idec_side_gate #(
  parameter int NUM_GP = 4
) (
  input  logic              mute,
  input  logic [NUM_GP-1:0] gp_in,
  input  logic              pc_in,
  input  logic              wr_in,
  input  logic              step_in,
  output logic [NUM_GP-1:0] gp_out,
  output logic              pc_out,
  output logic              wr_out,
  output logic              step_out
);
  always_comb begin
    gp_out   = mute ? '0 : gp_in;
    pc_out   = pc_in   & ~mute;
    wr_out   = wr_in   & ~mute;
    step_out = step_in & ~mute;
  end
endmodule

// File: rtl/micro_decoder.sv
module micro_decoder
  import idec_pkg::*;
#(
  parameter int NUM_GP = 4
) (
  input  logic [WORD_W-1:0] fetch_word,
  input  logic [WORD_W-1:0] scan_word,
  input  logic              scan_sel,
  input  logic              suppress,
  output logic [SEL_W-1:0]  data_sel,
  output logic [NUM_GP-1:0] gp_load,
  output logic              pc_load,
  output logic              mem_wr,
  output logic              pc_step,
  output logic [IMM_W-1:0]  imm_data
);
  localparam int DEST_SLOTS = NUM_GP + 1;

  logic [WORD_W-1:0] active_word;
  instr_fields_t     f;
  logic [NUM_GP-1:0] raw_gp;
  logic              raw_pc;

  initial begin
    if (DEST_SLOTS > (1 << DST_W)) $error("destination code field too narrow");
  end

  idec_word_pick #(.WIDTH(WORD_W)) u_pick (
    .primary(fetch_word), .alternate(scan_word), .pick_alt(scan_sel),
    .chosen(active_word));

  idec_field_split u_split (.word(active_word), .fields(f));

  idec_dest_decode #(.CODE_W(DST_W), .NUM_GP(NUM_GP)) u_dest (
    .code(f.dst), .gp_hit(raw_gp), .pc_hit(raw_pc));

  idec_side_gate #(.NUM_GP(NUM_GP)) u_gate (
    .mute(suppress), .gp_in(raw_gp), .pc_in(raw_pc), .wr_in(f.wr),
    .step_in(f.step), .gp_out(gp_load), .pc_out(pc_load),
    .wr_out(mem_wr), .step_out(pc_step));

  assign data_sel = f.src;
  assign imm_data = f.imm;

  always_comb begin
    AST_ONE_LOAD_MAX: assert ($countones({gp_load, pc_load}) <= 1); // R11
    AST_MUTE_CLEARS: assert (!suppress || ({gp_load, pc_load, mem_wr, pc_step} == '0)); // R9
    AST_PC_LOAD_CODE: assert (!pc_load || (f.dst == DST_W'(NUM_GP))); // R3
    AST_HIGH_CODE_IDLE: assert ((int'(f.dst) <= NUM_GP) || ({gp_load, pc_load} == '0)); // R4
    AST_GP_MATCH_CODE: assert (!(|gp_load) || (gp_load == (NUM_GP'(1) << f.dst))); // R2
  end
endmodule

// File: tb/micro_decoder_test.sv
module micro_decoder_test;
  logic        clk = 1'b0;
  logic [15:0] fetch_word, scan_word;
  logic        scan_sel, suppress;
  logic [2:0]  data_sel;
  logic [3:0]  gp_load;
  logic        pc_load, mem_wr, pc_step;
  logic [7:0]  imm_data;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  micro_decoder uut (
    .fetch_word(fetch_word), .scan_word(scan_word), .scan_sel(scan_sel),
    .suppress(suppress), .data_sel(data_sel), .gp_load(gp_load),
    .pc_load(pc_load), .mem_wr(mem_wr), .pc_step(pc_step), .imm_data(imm_data));

  function automatic logic [3:0] exp_gp(logic [15:0] w, logic m);
    if (m || w[12:10] > 3'd3) return 4'b0;
    return 4'b0001 << w[12:10];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] fw, logic [15:0] sw, logic ss, logic m);
    logic [15:0] w;
    string ltag;
    @(posedge clk);
    fetch_word = fw; scan_word = sw; scan_sel = ss; suppress = m;
    @(negedge clk);
    w = ss ? sw : fw;
    if (m) ltag = "R9 loads";
    else if (w[12:10] < 3'd4) ltag = "R2 loads";
    else if (w[12:10] == 3'd4) ltag = "R3 loads";
    else ltag = "R4 loads";
    check("R1 sel", 16'(data_sel), 16'(w[15:13]));
    check(ltag, 16'({gp_load, pc_load}),
          16'({exp_gp(w, m), (!m && w[12:10] == 3'd4)}));
    check(m ? "R9 wr" : "R5 wr", 16'(mem_wr), 16'(!m && w[9]));
    check(m ? "R9 step" : "R6 step", 16'(pc_step), 16'(!m && w[8]));
    check("R7 imm", 16'(imm_data), 16'(w[7:0]));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  s0;
    logic [7:0]  im0;
    void'($urandom(32'd20240517));
    fetch_word = '0; scan_word = '0; scan_sel = 0; suppress = 0;
    // R10: the all-zero word is a no-op copy of R0
    apply(16'h0000, 16'hFFFF, 1'b0, 1'b0);
    check("R10 nop", 16'({data_sel, gp_load, pc_load, mem_wr, pc_step}),
          16'({3'd0, 4'b0001, 3'b000}));
    // R2/R3/R4: walk every destination code, with and without suppress
    for (int d = 0; d < 8; d++) begin
      apply({3'd5, 3'(d), 2'b11, 8'hA5}, 16'h0, 1'b0, 1'b0);
      apply({3'd2, 3'(d), 2'b10, 8'h3C}, 16'h0, 1'b0, 1'b1);
    end
    // R8: scan word decoded; fetch word changes ignored while scan_sel high
    apply(16'h2600, 16'hD3C7, 1'b1, 1'b0);
    s0 = data_sel; im0 = imm_data;
    apply(16'hFFFF, 16'hD3C7, 1'b1, 1'b0);
    check("R8 ignore", 16'({s0, im0}), 16'({data_sel, imm_data}));
    apply(16'h2600, 16'hD3C7, 1'b0, 1'b0);
    check("R8 fetch", 16'(imm_data), 16'h0000);
    // R9: suppress keeps selector and immediate valid
    apply(16'hF3FF, 16'h0, 1'b0, 1'b1);
    check("R9 sel kept", 16'({data_sel, imm_data}), 16'({3'd7, 8'hFF}));
    // random mix; R11 exclusivity checked on each
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), 1'(($urandom % 4) == 0));
      check("R11 onehot", 16'($countones({gp_load, pc_load}) <= 1), 16'd1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule